// File: doc/BRIEF.md
# AES Instruction Fault Gate

This combinational block decides, for one AES-class instruction about to issue, whether it may run or must trap, and with which fault. It looks at the current processor mode, a handful of control flags, the AES feature flag and the lock-prefix flag. For memory operands it also looks at the effective address, whether the access goes through the stack segment, a segment-limit violation flag produced elsewhere, and a page-fault flag from the translation logic. It does no translation and no limit arithmetic of its own. It only applies the per-mode rules and the priority order.

The result is a three-bit fault code together with a valid bit. The issue logic uses it to choose between retiring the instruction and handing the fault to the delivery machinery. The operand is 16 bytes wide and must sit on a 16-byte boundary in every mode. The address range that is legal depends on the mode.

Top module: `aes_fault_gate`

## Requirements
- R1: `cpu_mode` encodes 0 = real, 1 = virtual-8086, 2 = protected, 3 = compatibility, 4 = 64-bit, and codes 5 to 7 follow the protected rules. `fault_code` encodes 0 = none, 1 = invalid opcode, 2 = device not available, 3 = general protection, 4 = stack fault, 5 = page fault. `fault_valid` is 1 exactly when `fault_code` is not 0.
- R2: Invalid opcode (1) is reported when `cr0_em` is 1, `cr4_fxsr_en` is 0, `aes_present` is 0 or `lock_pfx` is 1, and it overrides every other fault.
- R3: Device not available (2) is reported when `cr0_ts` is 1 and no invalid-opcode condition holds. It overrides all memory faults.
- R4: With `mem_op` at 0, no memory fault is reported, whatever the address, limit or page-fault inputs.
- R5: A memory operand whose `eff_addr[3:0]` is not zero gives general protection (3) in every mode. This holds even when a stack-segment limit violation is also flagged.
- R6: In real and virtual-8086 mode, an aligned operand whose last byte (`eff_addr`+15) lies above FFFFh gives general protection (3).
- R7: In protected, compatibility and reserved modes, `seg_limit_fault` gives stack fault (4) when `seg_is_stack` is 1, and general protection (3) otherwise.
- R8: In 64-bit mode, an address whose first or last byte has bits [63:47] not all equal gives stack fault (4) when `seg_is_stack` is 1, and general protection (3) otherwise. `seg_limit_fault` has no effect in 64-bit, real and virtual-8086 mode.
- R9: `page_fault` gives page fault (5) only when no other fault applies and the mode is not real mode. In real mode it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_mode | input | 3 | Processor mode code |
| cr0_em | input | 1 | Emulation flag |
| cr0_ts | input | 1 | Task-switched flag |
| cr4_fxsr_en | input | 1 | OS extended-state support enable |
| aes_present | input | 1 | AES feature flag |
| lock_pfx | input | 1 | Lock prefix present |
| mem_op | input | 1 | Operand comes from memory |
| eff_addr | input | ADDR_W | Effective address of the operand |
| seg_is_stack | input | 1 | Reference goes through the stack segment |
| seg_limit_fault | input | 1 | Segment-limit or illegal-address flag |
| page_fault | input | 1 | Translation reported a page fault |
| fault_valid | output | 1 | A fault must be raised |
| fault_code | output | 3 | Fault kind |

## Verification
The bench builds the block with its default parameters: a 64-bit address, a canonical boundary at bit 47, a 16-byte operand and a 16-bit real-mode window. With these values the exact edge cases can be reached with plain constants. These are an operand ending at FFFFh versus one starting at 10000h, and the last canonical lower-half line against the first non-canonical address. The stimulus walks each mode through overlapping fault conditions, so every step of the priority chain is exercised. It also checks that the inputs the rules declare irrelevant are really ignored.

// File: rtl/aes_fault_gate.sv
module aes_fault_gate #(
  parameter int ADDR_W     = 64,
  parameter int CANON_MSB  = 47,
  parameter int OPND_BYTES = 16,
  parameter int REAL_W     = 16
) (
  input  logic [2:0]        cpu_mode,
  input  logic              cr0_em,
  input  logic              cr0_ts,
  input  logic              cr4_fxsr_en,
  input  logic              aes_present,
  input  logic              lock_pfx,
  input  logic              mem_op,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              seg_is_stack,
  input  logic              seg_limit_fault,
  input  logic              page_fault,
  output logic              fault_valid,
  output logic [2:0]        fault_code
);
  localparam int ALIGN_W = $clog2(OPND_BYTES);
  localparam logic [ADDR_W:0] LAST_OFS = (ADDR_W+1)'(OPND_BYTES - 1);

  localparam logic [2:0] F_NONE = 3'd0;
  localparam logic [2:0] F_UD   = 3'd1;
  localparam logic [2:0] F_NM   = 3'd2;
  localparam logic [2:0] F_GP   = 3'd3;
  localparam logic [2:0] F_SS   = 3'd4;
  localparam logic [2:0] F_PF   = 3'd5;

  logic              is_real, is_v86, is_long, is_seg;
  logic              bad_opcode, misalign, real_oob, noncanon;
  logic [ADDR_W:0]   last_ext;
  logic [2:0]        seg_kind;

  function automatic logic canonical(input logic [ADDR_W-1:0] a);
    return (&a[ADDR_W-1:CANON_MSB]) || !(|a[ADDR_W-1:CANON_MSB]);
  endfunction

  assign is_real  = (cpu_mode == 3'd0);
  assign is_v86   = (cpu_mode == 3'd1);
  assign is_long  = (cpu_mode == 3'd4);
  assign is_seg   = !is_real && !is_v86 && !is_long;

  assign bad_opcode = cr0_em || !cr4_fxsr_en || !aes_present || lock_pfx;
  assign misalign   = |eff_addr[ALIGN_W-1:0];
  assign last_ext   = {1'b0, eff_addr} + LAST_OFS;
  assign real_oob   = |last_ext[ADDR_W:REAL_W];
  assign noncanon   = !canonical(eff_addr) || !canonical(last_ext[ADDR_W-1:0]);
  assign seg_kind   = seg_is_stack ? F_SS : F_GP;

  always_comb begin
    fault_code = F_NONE;
    if (bad_opcode)                           fault_code = F_UD;
    else if (cr0_ts)                          fault_code = F_NM;
    else if (mem_op) begin
      if (misalign)                           fault_code = F_GP;
      else if ((is_real || is_v86) && real_oob) fault_code = F_GP;
      else if (is_seg && seg_limit_fault)     fault_code = seg_kind;
      else if (is_long && noncanon)           fault_code = seg_kind;
      else if (!is_real && page_fault)        fault_code = F_PF;
    end
  end

  assign fault_valid = (fault_code != F_NONE);
endmodule

module aes_fault_gate_chk (
  input logic [2:0] cpu_mode,
  input logic       cr0_em,
  input logic       cr0_ts,
  input logic       cr4_fxsr_en,
  input logic       aes_present,
  input logic       lock_pfx,
  input logic       mem_op,
  input logic [3:0] addr_lo,
  input logic       fault_valid,
  input logic [2:0] fault_code
);
  logic ud_cond;
  assign ud_cond = cr0_em || !cr4_fxsr_en || !aes_present || lock_pfx;

  always_comb begin
    // R1
    valid_code_chk: assert (fault_valid == (fault_code != 3'd0) && fault_code <= 3'd5);
    // R2
    ud_first_chk: assert (!ud_cond || fault_code == 3'd1);
    // R3
    nm_next_chk: assert (ud_cond || !cr0_ts || fault_code == 3'd2);
    // R4
    reg_only_chk: assert (mem_op || ud_cond || cr0_ts || !fault_valid);
    // R5
    misalign_chk: assert (!mem_op || ud_cond || cr0_ts || addr_lo == 4'd0 || fault_code == 3'd3);
    // R9
    real_no_pf_chk: assert (cpu_mode != 3'd0 || fault_code != 3'd5);
  end
endmodule

bind aes_fault_gate aes_fault_gate_chk chk_i (
  .cpu_mode    (cpu_mode),
  .cr0_em      (cr0_em),
  .cr0_ts      (cr0_ts),
  .cr4_fxsr_en (cr4_fxsr_en),
  .aes_present (aes_present),
  .lock_pfx    (lock_pfx),
  .mem_op      (mem_op),
  .addr_lo     (eff_addr[3:0]),
  .fault_valid (fault_valid),
  .fault_code  (fault_code)
);

// File: tb/aes_fault_gate_tb_top.sv
module aes_fault_gate_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [2:0]  cpu_mode;
  logic        cr0_em, cr0_ts, cr4_fxsr_en, aes_present, lock_pfx;
  logic        mem_op, seg_is_stack, seg_limit_fault, page_fault;
  logic [63:0] eff_addr;
  logic        fault_valid;
  logic [2:0]  fault_code;

  aes_fault_gate dut_i (
    .cpu_mode(cpu_mode), .cr0_em(cr0_em), .cr0_ts(cr0_ts),
    .cr4_fxsr_en(cr4_fxsr_en), .aes_present(aes_present), .lock_pfx(lock_pfx),
    .mem_op(mem_op), .eff_addr(eff_addr), .seg_is_stack(seg_is_stack),
    .seg_limit_fault(seg_limit_fault), .page_fault(page_fault),
    .fault_valid(fault_valid), .fault_code(fault_code)
  );

  typedef struct {
    logic [2:0] code;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   drv_done = 1'b0;

  task automatic drive(input logic [2:0] mode, input logic em, input logic ts,
                       input logic fx, input logic aes, input logic lk,
                       input logic mem, input logic [63:0] addr, input logic stk,
                       input logic lim, input logic pf, input logic [2:0] exp,
                       input string tag);
    @(negedge clk);
    cpu_mode = mode; cr0_em = em; cr0_ts = ts; cr4_fxsr_en = fx;
    aes_present = aes; lock_pfx = lk; mem_op = mem; eff_addr = addr;
    seg_is_stack = stk; seg_limit_fault = lim; page_fault = pf;
    exp_q.push_back('{code: exp, tag: tag});
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (!rst && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (fault_code !== e.code || fault_valid !== (e.code != 3'd0)) begin
          n_fail++;
          $display("FAIL %s: code=%0d valid=%0b expected code=%0d valid=%0b",
                   e.tag, fault_code, fault_valid, e.code, e.code != 3'd0);
        end
      end
    end
  end

  initial begin : driver
    cpu_mode = 3'd2; cr0_em = 0; cr0_ts = 0; cr4_fxsr_en = 1; aes_present = 1;
    lock_pfx = 0; mem_op = 0; eff_addr = '0; seg_is_stack = 0;
    seg_limit_fault = 0; page_fault = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(3'd2,0,0,1,1,0, 0, 64'h0,      0,0,0, 3'd0, "R1 reset idle");
    drive(3'd2,1,0,1,1,0, 0, 64'h0,      0,0,0, 3'd1, "R2 em set");
    drive(3'd0,0,0,0,1,0, 0, 64'h0,      0,0,0, 3'd1, "R2 fxsr off");
    drive(3'd4,0,0,1,0,0, 1, 64'h3,      0,0,1, 3'd1, "R2 no aes");
    drive(3'd1,0,1,1,1,1, 0, 64'h0,      0,0,0, 3'd1, "R2 lock over ts");
    drive(3'd2,0,1,1,1,0, 0, 64'h0,      0,0,0, 3'd2, "R3 ts");
    drive(3'd2,0,1,1,1,0, 1, 64'h1003,   1,1,1, 3'd2, "R3 ts over mem");
    drive(3'd2,0,0,1,1,0, 0, 64'h1003,   1,1,1, 3'd0, "R4 reg only");
    drive(3'd2,0,0,1,1,0, 1, 64'h1003,   0,0,0, 3'd3, "R5 prot misalign");
    drive(3'd3,0,0,1,1,0, 1, 64'h1008,   1,1,0, 3'd3, "R5 misalign over ss");
    drive(3'd4,0,0,1,1,0, 1, 64'h7,      0,0,1, 3'd3, "R5 long misalign");
    drive(3'd0,0,0,1,1,0, 1, 64'hFFF0,   0,0,0, 3'd0, "R6 real top ok");
    drive(3'd0,0,0,1,1,0, 1, 64'h10000,  0,0,0, 3'd3, "R6 real over");
    drive(3'd1,0,0,1,1,0, 1, 64'h20000,  0,0,1, 3'd3, "R6 v86 over");
    drive(3'd2,0,0,1,1,0, 1, 64'h2000,   0,1,0, 3'd3, "R7 prot limit");
    drive(3'd3,0,0,1,1,0, 1, 64'h2000,   1,1,0, 3'd4, "R7 compat stack");
    drive(3'd6,0,0,1,1,0, 1, 64'h2000,   1,1,0, 3'd4, "R1 reserved mode");
    drive(3'd4,0,0,1,1,0, 1, 64'h0000_8000_0000_0000, 0,0,0, 3'd3, "R8 noncanon");
    drive(3'd4,0,0,1,1,0, 1, 64'h0000_8000_0000_0000, 1,0,0, 3'd4, "R8 noncanon stack");
    drive(3'd4,0,0,1,1,0, 1, 64'hFFFF_8000_0000_0000, 1,1,0, 3'd0, "R8 canon upper");
    drive(3'd4,0,0,1,1,0, 1, 64'h0000_7FFF_FFFF_FFF0, 0,0,0, 3'd0, "R8 canon last line");
    drive(3'd0,0,0,1,1,0, 1, 64'h100,    0,1,0, 3'd0, "R8 limit ignored real");
    drive(3'd0,0,0,1,1,0, 1, 64'h100,    0,0,1, 3'd0, "R9 real pf ignored");
    drive(3'd1,0,0,1,1,0, 1, 64'hFFF0,   0,0,1, 3'd5, "R9 v86 pf");
    drive(3'd2,0,0,1,1,0, 1, 64'h2000,   0,1,1, 3'd3, "R9 pf below gp");
    drive(3'd4,0,0,1,1,0, 1, 64'h4000,   1,0,1, 3'd5, "R9 long pf");
    repeat (3) @(posedge clk);
    drv_done = 1'b1;
  end

  initial begin : watchdog
    int cyc = 0;
    while (!drv_done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!drv_done || exp_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: done=%0b pending=%0d expected done=1 pending=0",
               drv_done, exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule